// File: doc/BRIEF.md
# RISC Integer ALU with Compare

This block is the execute-stage arithmetic-logic unit of a small three-operand load-store RISC datapath. It is purely combinational. It takes two 32-bit source operands, a dedicated 5-bit shift count and a 4-bit operation code, and returns a 32-bit result together with a flag that is high when that result is zero. The result settles in the same cycle the inputs change, and the surrounding pipeline registers capture it.

Nine operations are offered:
- two's complement add and subtract;
- bitwise AND, OR and NOR, where NOR against a zero operand acts as bitwise NOT;
- zero-filling left and right shifts of operand B by the shift count;
- signed and unsigned set-on-less-than.

There is no subtract-by-constant operation, because the datapath adds a negative constant instead. The zero flag lets an equality branch be resolved from a subtract.

Top module: `rva_alu`

## Requirements
- R1: Operation code 0 (add) returns (A + B) mod 2^32 with no trap. Adding 0xFFFFFFFF therefore decrements A.
- R2: Operation code 1 (subtract) returns (A - B) mod 2^32 with no trap.
- R3: Operation code 2 returns A AND B, and operation code 3 returns A OR B.
- R4: Operation code 4 returns NOT (A OR B). With B equal to zero, the result is the bitwise inverse of A.
- R5: Operation code 5 shifts B left by the 5-bit shift count and fills vacated bits with zero. A count of 0 returns B unchanged.
- R6: Operation code 6 shifts B right by the shift count and fills vacated bits with zero. A count of 31 leaves only bit 0, which holds the old bit 31.
- R7: Operation code 7 (signed set-less-than) returns 1 when A < B as two's complement numbers, and 0 otherwise.
- R8: Operation code 8 (unsigned set-less-than) returns 1 when A < B as unsigned numbers. For A = 0xFFFFFFFF and B = 0x00000001, code 7 returns 1 and code 8 returns 0.
- R9: The zero flag is 1 exactly when the 32-bit result is zero. After a subtract, it is 1 exactly when A equals B.
- R10: Operation codes 9 to 15 are unused. They give a result of zero and a zero flag of 1.
- R11: Both set-less-than results are zero-extended, so bits 31 down to 1 are always 0.
- R12: The shift count has no effect on operations other than codes 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 nor, 5 shift left, 6 shift right, 7 signed less-than, 8 unsigned less-than) |
| a_i | input | 32 | First source operand |
| b_i | input | 32 | Second source operand; the value shifted by codes 5 and 6 |
| shamt_i | input | 5 | Shift count for codes 5 and 6 |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The block holds no state, so any fault shows at the ports in the same cycle the operands are presented. A wrong carry from the adder, or a wrong sign decision in the comparator, gives the wrong set-less-than bit at once. Mixed-sign operand pairs are where the signed and unsigned forms must disagree, and they expose such a fault. A wrong stage in the shifter shows as a misplaced or missing bit for every count with that stage's bit set, which is why counts of 0, 1, 16 and 31 are driven alongside random ones.

// File: rtl/rva_pkg.sv
`timescale 1ns/1ps
package rva_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned SHAMT_W = $clog2(WORD_W);
  localparam int unsigned OP_W    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SLT  = 4'd7,
    OP_SLTU = 4'd8
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_NOR = 2'd2
  } logic_sel_e;
endpackage

// File: rtl/rva_addsub.sv
`timescale 1ns/1ps
module rva_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   total;

  assign b_eff = b_i ^ {W{sub_i}};
  assign total = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o   = total[W-1:0];
  assign carry_o = total[W];
endmodule

// File: rtl/rva_compare.sv
`timescale 1ns/1ps
module rva_compare #(
  parameter int unsigned W = 32
) (
  input  logic         a_msb_i,
  input  logic         b_msb_i,
  input  logic [W-1:0] diff_i,
  input  logic         carry_i,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  logic signs_differ;

  // a - b borrows exactly when a < b unsigned: no carry out of a + ~b + 1
  assign lt_u_o       = ~carry_i;
  assign signs_differ = a_msb_i ^ b_msb_i;
  // opposite signs: the negative one is smaller; same signs: difference sign decides
  assign lt_s_o       = signs_differ ? a_msb_i : diff_i[W-1];
endmodule

// File: rtl/rva_logic.sv
`timescale 1ns/1ps
module rva_logic
  import rva_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] y_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic ored;
    assign ored = a_i[i] | b_i[i];
    always_comb begin
      unique case (sel_i)
        LG_AND:  y_o[i] = a_i[i] & b_i[i];
        LG_OR:   y_o[i] = ored;
        LG_NOR:  y_o[i] = ~ored;
        default: y_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rva_shift.sv
`timescale 1ns/1ps
module rva_shift #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  input  logic          right_i,
  output logic [W-1:0]  y_o
);
  logic [W-1:0]       data_rev;
  logic [W-1:0]       out_rev;
  logic [SW:0][W-1:0] stg;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign data_rev[i] = data_i[W-1-i];
    assign out_rev[i]  = stg[SW][W-1-i];
  end

  // right shifts reuse the left-shift ladder on bit-reversed data
  assign stg[0] = right_i ? data_rev : data_i;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int unsigned DIST = 1 << s;
    assign stg[s+1] = amt_i[s] ? (stg[s] << DIST) : stg[s];
  end

  assign y_o = right_i ? out_rev : stg[SW];
endmodule

// File: rtl/rva_alu.sv
`timescale 1ns/1ps
module rva_alu
  import rva_pkg::*;
(
  input  logic [OP_W-1:0]    op_i,
  input  logic [WORD_W-1:0]  a_i,
  input  logic [WORD_W-1:0]  b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [WORD_W-1:0]  result_o,
  output logic               zero_o
);
  alu_op_e              op;
  logic                 do_sub;
  logic [WORD_W-1:0]    sum;
  logic                 carry;
  logic                 lt_s;
  logic                 lt_u;
  logic_sel_e           lsel;
  logic [WORD_W-1:0]    lres;
  logic [WORD_W-1:0]    sres;
  logic [WORD_W-1:0]    res;

  assign op     = alu_op_e'(op_i);
  assign do_sub = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);

  always_comb begin
    unique case (op)
      OP_OR:   lsel = LG_OR;
      OP_NOR:  lsel = LG_NOR;
      default: lsel = LG_AND;
    endcase
  end

  rva_addsub #(.W(WORD_W)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (do_sub),
    .sum_o  (sum),
    .carry_o(carry)
  );

  rva_compare #(.W(WORD_W)) u_compare (
    .a_msb_i(a_i[WORD_W-1]),
    .b_msb_i(b_i[WORD_W-1]),
    .diff_i (sum),
    .carry_i(carry),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  rva_logic #(.W(WORD_W)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .sel_i(lsel),
    .y_o  (lres)
  );

  rva_shift #(.W(WORD_W), .SW(SHAMT_W)) u_shift (
    .data_i (b_i),
    .amt_i  (shamt_i),
    .right_i(op == OP_SRL),
    .y_o    (sres)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:        res = sum;
      OP_AND, OP_OR, OP_NOR: res = lres;
      OP_SLL, OP_SRL:        res = sres;
      OP_SLT:                res = {{(WORD_W-1){1'b0}}, lt_s};
      OP_SLTU:               res = {{(WORD_W-1){1'b0}}, lt_u};
      default:               res = '0;
    endcase
  end

  assign result_o = res;
  assign zero_o   = ~|res;
endmodule

// File: rtl/rva_alu_checks.sv
`timescale 1ns/1ps
module rva_alu_checks #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 5
) (
  input logic [3:0]    op_i,
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic [SW-1:0] shamt_i,
  input logic [W-1:0]  result_o,
  input logic          zero_o
);
  always_comb begin
    if (op_i == 4'd7 || op_i == 4'd8)
      AST_SLT_NARROW: assert (result_o[W-1:1] == '0);  // R11
    if (op_i > 4'd8)
      AST_UNUSED_ZERO: assert (result_o == '0 && zero_o);  // R10
    if (op_i == 4'd1)
      AST_SUB_EQUAL: assert (zero_o == (a_i == b_i));  // R9
    if (op_i == 4'd4 && b_i == '0)
      AST_NOR_NOT: assert (result_o == ~a_i);  // R4
    if (op_i == 4'd5 && shamt_i == '0)
      AST_SHIFT_NONE: assert (result_o == b_i);  // R5
    if (op_i == 4'd7 && a_i[W-1] != b_i[W-1])
      AST_SIGN_SPLIT: assert (result_o[0] == a_i[W-1]);  // R7
    if (op_i == 4'd8 && a_i[W-1] != b_i[W-1])
      AST_UNSIGNED_SPLIT: assert (result_o[0] == b_i[W-1]);  // R8
  end
endmodule

bind rva_alu rva_alu_checks #(.W(32), .SW(5)) u_chk (
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .shamt_i (shamt_i),
  .result_o(result_o),
  .zero_o  (zero_o)
);

// File: tb/rva_alu_bench.sv
`timescale 1ns/1ps
module rva_alu_bench;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op;
  logic [31:0] a;
  logic [31:0] b;
  logic [4:0]  sh;
  logic [31:0] result;
  logic        zero;
  int          n_run;
  int          n_fail;

  rva_alu u_rva_alu (
    .op_i    (op),
    .a_i     (a),
    .b_i     (b),
    .shamt_i (sh),
    .result_o(result),
    .zero_o  (zero)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] x,
                                        input logic [31:0] y, input logic [4:0] s);
    case (o)
      4'd0: return x + y;
      4'd1: return x - y;
      4'd2: return x & y;
      4'd3: return x | y;
      4'd4: return ~(x | y);
      4'd5: return y << s;
      4'd6: return y >> s;
      4'd7: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'd8: return (x < y) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] o, input logic [31:0] x,
                       input logic [31:0] y, input logic [4:0] s);
    logic [31:0] exp_r;
    logic        exp_z;
    @(posedge clk);
    op = o; a = x; b = y; sh = s;
    @(negedge clk);
    exp_r = model(o, x, y, s);
    exp_z = (exp_r == 32'd0);
    n_run++;
    if (result !== exp_r || zero !== exp_z) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got %h/%b expected %h/%b",
               req, o, x, y, s, result, zero, exp_r, exp_z);
    end
  endtask

  task automatic expect_val(input string req, input logic [31:0] want);
    n_run++;
    if (result !== want) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, result, want);
    end
  endtask

  initial begin
    #1200000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    op = '0; a = '0; b = '0; sh = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_run++;
    if (result !== 32'd0 || zero !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 idle: got %h/%b expected 00000000/1", result, zero);
    end

    // R1 wrap and add of a negative constant
    check("R1", 4'd0, 32'hFFFF_FFFF, 32'd1, 5'd0);
    check("R1", 4'd0, 32'd100, 32'hFFFF_FFFF, 5'd0);
    expect_val("R1 decrement", 32'd99);
    check("R1", 4'd0, 32'h7FFF_FFFF, 32'd1, 5'd0);
    // R2
    check("R2", 4'd1, 32'd0, 32'd1, 5'd0);
    check("R2", 4'd1, 32'h8000_0000, 32'd1, 5'd0);
    // R9 equality via subtract
    check("R9", 4'd1, 32'h1234_5678, 32'h1234_5678, 5'd3);
    check("R9", 4'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 5'd0);
    // R3
    check("R3", 4'd2, 32'h0000_3C00, 32'h0000_0DC0, 5'd0);
    check("R3", 4'd3, 32'h0000_3C00, 32'h0000_0DC0, 5'd0);
    // R4 NOT through NOR
    check("R4", 4'd4, 32'h0000_3C00, 32'd0, 5'd0);
    expect_val("R4 not", 32'hFFFF_C3FF);
    check("R4", 4'd4, 32'hFFFF_FFFF, 32'd0, 5'd0);
    // R5 / R6 shift boundaries
    check("R5", 4'd5, 32'hDEAD_BEEF, 32'h8000_0001, 5'd0);
    check("R5", 4'd5, 32'd0, 32'hFFFF_FFFF, 5'd31);
    check("R5", 4'd5, 32'd0, 32'h0000_FFFF, 5'd16);
    check("R6", 4'd6, 32'd0, 32'h8000_0000, 5'd31);
    expect_val("R6 top bit", 32'd1);
    check("R6", 4'd6, 32'd0, 32'hFFFF_FFFF, 5'd1);
    check("R6", 4'd6, 32'd0, 32'h1234_5678, 5'd0);
    // R7 / R8 / R11 signed versus unsigned
    check("R7", 4'd7, 32'hFFFF_FFFF, 32'd1, 5'd0);
    expect_val("R7 minus one", 32'd1);
    check("R8", 4'd8, 32'hFFFF_FFFF, 32'd1, 5'd0);
    expect_val("R8 max", 32'd0);
    check("R7", 4'd7, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
    check("R8", 4'd8, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
    check("R11", 4'd7, 32'h8000_0000, 32'h7FFF_FFFF, 5'd9);
    check("R7", 4'd7, 32'd5, 32'd5, 5'd0);
    // R10 unused codes
    for (int c = 9; c < 16; c++) check("R10", 4'(c), 32'hFFFF_FFFF, 32'h1234_5678, 5'd7);
    // R12 shift count ignored elsewhere
    for (int c = 0; c < 5; c++) begin
      check("R12", 4'(c), 32'h0F0F_1234, 32'h00FF_8001, 5'd0);
      check("R12", 4'(c), 32'h0F0F_1234, 32'h00FF_8001, 5'd19);
    end
    // random sweep over every code
    for (int i = 0; i < 3000; i++)
      check("R1-R12 random", 4'($urandom_range(0, 15)), $urandom, $urandom, 5'($urandom));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule